// File: doc/BRIEF.md
# USB Device Endpoint Status Tracker

This block keeps the outcome of the most recent transaction for each endpoint of a USB device controller. It sits between the serial engine and an 8-bit microprocessor command port. For every endpoint (control OUT, control IN and endpoints 1 to 14) the serial engine reports a completed transaction with a pulse. The pulse carries a 4-bit error code, a success flag and the data PID. The tracker stores these fields in a status byte. The microprocessor fetches that byte with a one-byte read command.

The tracker also manages the set-up handshake on the two control endpoints. When a set-up packet arrives, buffer validate and clear commands aimed at control OUT or control IN are locked out until firmware sends an acknowledge. A second set-up packet arriving inside that window raises an overwrite flag. Firmware reads this flag through a separate image byte, which also shows whether the buffer holds set-up data and which CPU buffer is selected.

Top module: `ep_status_tracker`

## Requirements
- R1: A command in A0h..AFh (endpoint index = code − A0h: 0 control OUT, 1 control IN, 2..15 endpoints 1..14) makes `rdValid` high for exactly the cycle after the command cycle, and `rdData` holds the status byte in that cycle.
- R2: The status byte reads {bit7 overflow, bit6 PID (0 DATA0, 1 DATA1), bit5 zero, bits4:1 error code, bit0 OK}, and an event pulse replaces the stored error code, PID and OK fields of its endpoint.
- R3: An event on an endpoint whose status has not been read since its previous event sets bit 7 of that endpoint's byte.
- R4: A status read clears bit 7 and marks the status as read; the error code, PID and OK fields are retained.
- R5: When a read and an event reach the same endpoint in the same cycle, the read returns the old byte and the event is stored as if the read had not happened.
- R6: After reset every status byte reads 00h, `rdValid` and the command strobes are low, and `ctrlBufEn` is high.
- R7: A set-up pulse drops `ctrlBufEn` from the next cycle. While it is low, a validate command (60h + index) or clear command (70h + index) for index 0 or 1 produces no strobe and a one-cycle `cmdReject` pulse. The same commands on other endpoints still strobe `validateStb`/`clearStb` with `bufEp` = index.
- R8: Command F4h (no data phase) raises `ctrlBufEn` again; a set-up pulse in the same cycle wins and keeps the lock.
- R9: A set-up pulse that arrives while the lock is already held sets the set-up overwrite flag.
- R10: Command B4h returns the image byte {bits7:4 zero, bit3 overwrite, bit2 set-up in buffer, bit1 `cpuBufSel`, bit0 zero}. The overwrite flag clears on that read only if `setupWriteDone` is high during the command.
- R11: The set-up-in-buffer flag is set by a set-up pulse and cleared by an accepted clear command on control OUT (70h).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command byte strobe from the microprocessor |
| cmdCode | input | 8 | Command code |
| cpuBufSel | input | 1 | Currently selected CPU buffer (0 primary, 1 secondary) |
| setupRcvd | input | 1 | Pulse: a set-up packet was written to control OUT |
| setupWriteDone | input | 1 | Level: set-up data write has finished |
| evtValid | input | 16 | Per-endpoint transaction-complete pulse |
| evtErr | input | 64 | Per-endpoint 4-bit error code, endpoint i at [4i+3:4i] |
| evtOk | input | 16 | Per-endpoint success flag |
| evtPid | input | 16 | Per-endpoint data PID (0 DATA0, 1 DATA1) |
| rdData | output | 8 | Returned status or image byte |
| rdValid | output | 1 | rdData carries a reply |
| ctrlBufEn | output | 1 | Control endpoint buffer commands enabled |
| validateStb | output | 1 | Accepted validate-buffer command |
| clearStb | output | 1 | Accepted clear-buffer command |
| bufEp | output | 4 | Endpoint index of the buffer command |
| cmdReject | output | 1 | Buffer command refused by the set-up lock |

## Verification
The bench builds the tracker with its defaults: sixteen endpoints, two control endpoints and the command bases A0h, 60h, 70h, F4h and B4h. With these values the lowest and highest read codes (A0h, AFh) address real endpoints. Both control indices can be driven into the lockout, and endpoint 5 shows that commands outside the control pair still pass while it is held. The image read is exercised with `setupWriteDone` both low and high, so that the conditional clear of the overwrite flag is visible at the data port.

// File: rtl/ep_status_pkg.sv
package ep_status_pkg;

  localparam int EP_IDX_W = 4;
  localparam int BYTE_W   = 8;

  typedef logic [EP_IDX_W-1:0] epIdx_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   rdStatus;
    logic   rdImage;
    epIdx_t ep;
  } dpStrb_t;

endpackage

// File: rtl/ep_status_cell.sv
module ep_status_cell #(
  parameter int ERR_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtValid,
  input  logic [ERR_W-1:0] evtErr,
  input  logic             evtOk,
  input  logic             evtPid,
  input  logic             rdClr,
  output logic [7:0]       statusByte
);

  localparam int PAD_W = 8 - 3 - ERR_W;

  logic             pending;
  logic             ovf;
  logic             pidReg;
  logic             okReg;
  logic [ERR_W-1:0] errReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      ovf     <= 1'b0;
      pidReg  <= 1'b0;
      okReg   <= 1'b0;
      errReg  <= '0;
    end else if (evtValid) begin
      // event wins over a read landing in the same cycle
      errReg  <= evtErr;
      okReg   <= evtOk;
      pidReg  <= evtPid;
      ovf     <= ovf | pending;
      pending <= 1'b1;
    end else if (rdClr) begin
      ovf     <= 1'b0;
      pending <= 1'b0;
    end
  end

  assign statusByte = {ovf, pidReg, {PAD_W{1'b0}}, errReg, okReg};

  // R3: unread status followed by a new event flags overflow
  p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    evtValid && pending |=> statusByte[7]);

  // R4: a read without a colliding event clears the overflow bit
  p_rd_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdClr && !evtValid |=> !statusByte[7]);

  // R4: a read leaves the transaction fields untouched
  p_rd_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdClr && !evtValid |=> $stable(statusByte[6:0]));

endmodule

// File: rtl/ep_status_ctrl.sv
module ep_status_ctrl
  import ep_status_pkg::*;
#(
  parameter int         NUM_EP   = 16,
  parameter int         CTRL_EPS = 2,
  parameter logic [7:0] RD_BASE  = 8'hA0,
  parameter logic [7:0] VAL_BASE = 8'h60,
  parameter logic [7:0] CLR_BASE = 8'h70,
  parameter logic [7:0] ACK_CODE = 8'hF4,
  parameter logic [7:0] IMG_CODE = 8'hB4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  logic [7:0] cmdCode,
  input  logic    setupRcvd,
  input  logic    setupWriteDone,
  output dpStrb_t strb,
  output logic    validateStb,
  output logic    clearStb,
  output epIdx_t  bufEp,
  output logic    cmdReject,
  output logic    ctrlBufEn,
  output logic    ovwFlag,
  output logic    setupInBuf
);

  localparam logic [7:0] NUM_EP_B = 8'(NUM_EP);
  localparam logic [7:0] CTRL_B   = 8'(CTRL_EPS);

  logic [7:0] rdOff, valOff, clrOff;
  logic       isRd, isVal, isClr, isAck, isImg;
  logic       valCtrl, clrCtrl, lockReg;
  logic       valBlock, clrBlock;

  always_comb begin
    rdOff   = cmdCode - RD_BASE;
    valOff  = cmdCode - VAL_BASE;
    clrOff  = cmdCode - CLR_BASE;
    isRd    = cmdValid && (cmdCode >= RD_BASE)  && (rdOff  < NUM_EP_B);
    isVal   = cmdValid && (cmdCode >= VAL_BASE) && (valOff < NUM_EP_B);
    isClr   = cmdValid && (cmdCode >= CLR_BASE) && (clrOff < NUM_EP_B);
    isAck   = cmdValid && (cmdCode == ACK_CODE);
    isImg   = cmdValid && (cmdCode == IMG_CODE);
    valCtrl = valOff < CTRL_B;
    clrCtrl = clrOff < CTRL_B;
    valBlock = isVal && valCtrl && lockReg;
    clrBlock = isClr && clrCtrl && lockReg;

    strb.rdStatus = isRd;
    strb.rdImage  = isImg;
    strb.ep       = rdOff[EP_IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockReg     <= 1'b0;
      ovwFlag     <= 1'b0;
      setupInBuf  <= 1'b0;
      validateStb <= 1'b0;
      clearStb    <= 1'b0;
      cmdReject   <= 1'b0;
      bufEp       <= '0;
    end else begin
      // set-up lock: a set-up pulse beats a same-cycle acknowledge
      if (setupRcvd)  lockReg <= 1'b1;
      else if (isAck) lockReg <= 1'b0;

      // overwrite: new set-up inside an unacknowledged window
      if (setupRcvd && lockReg)          ovwFlag <= 1'b1;
      else if (isImg && setupWriteDone)  ovwFlag <= 1'b0;

      if (setupRcvd)                                   setupInBuf <= 1'b1;
      else if (isClr && !clrBlock && clrOff == 8'd0)   setupInBuf <= 1'b0;

      validateStb <= isVal && !valBlock;
      clearStb    <= isClr && !clrBlock;
      cmdReject   <= valBlock || clrBlock;
      if (isVal)      bufEp <= valOff[EP_IDX_W-1:0];
      else if (isClr) bufEp <= clrOff[EP_IDX_W-1:0];
    end
  end

  assign ctrlBufEn = !lockReg;

  // R7: a set-up pulse locks the control buffer commands
  p_setup_lock_r7: assert property (@(posedge clk) disable iff (!rstN)
    setupRcvd |=> !ctrlBufEn);

  // R9: second set-up while locked raises the overwrite flag
  p_ovw_raise_r9: assert property (@(posedge clk) disable iff (!rstN)
    setupRcvd && !ctrlBufEn |=> ovwFlag);

  // R10: without a finished write the overwrite flag survives a read
  p_ovw_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    ovwFlag && !setupWriteDone |=> ovwFlag);

  // R7: a refused command never strobes
  p_reject_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdReject |-> !validateStb && !clearStb);

endmodule

// File: rtl/ep_status_dp.sv
module ep_status_dp
  import ep_status_pkg::*;
#(
  parameter int NUM_EP = 16,
  parameter int ERR_W  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrb_t                 strb,
  input  logic [2:0]              imgBits,
  input  logic [NUM_EP-1:0]       evtValid,
  input  logic [NUM_EP*ERR_W-1:0] evtErr,
  input  logic [NUM_EP-1:0]       evtOk,
  input  logic [NUM_EP-1:0]       evtPid,
  output logic [BYTE_W-1:0]       rdData,
  output logic                    rdValid
);

  logic [BYTE_W-1:0] statBytes [NUM_EP];

  for (genvar i = 0; i < NUM_EP; i++) begin : g_cell
    logic rdClr;
    assign rdClr = strb.rdStatus && (strb.ep == EP_IDX_W'(i));
    ep_status_cell #(.ERR_W(ERR_W)) u_cell (
      .clk       (clk),
      .rstN      (rstN),
      .evtValid  (evtValid[i]),
      .evtErr    (evtErr[i*ERR_W +: ERR_W]),
      .evtOk     (evtOk[i]),
      .evtPid    (evtPid[i]),
      .rdClr     (rdClr),
      .statusByte(statBytes[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.rdStatus || strb.rdImage;
      if (strb.rdImage)
        rdData <= {4'b0000, imgBits, 1'b0};
      else if (strb.rdStatus)
        rdData <= statBytes[strb.ep];
    end
  end

  // R1: every decoded read yields one reply cycle
  p_rd_reply_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStatus || strb.rdImage) |=> rdValid);

  p_rd_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdStatus || strb.rdImage) |=> !rdValid);

endmodule

// File: rtl/ep_status_tracker.sv
module ep_status_tracker
  import ep_status_pkg::*;
#(
  parameter int         NUM_EP   = 16,
  parameter int         ERR_W    = 4,
  parameter int         CTRL_EPS = 2,
  parameter logic [7:0] RD_BASE  = 8'hA0,
  parameter logic [7:0] VAL_BASE = 8'h60,
  parameter logic [7:0] CLR_BASE = 8'h70,
  parameter logic [7:0] ACK_CODE = 8'hF4,
  parameter logic [7:0] IMG_CODE = 8'hB4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmdValid,
  input  logic [7:0]              cmdCode,
  input  logic                    cpuBufSel,
  input  logic                    setupRcvd,
  input  logic                    setupWriteDone,
  input  logic [NUM_EP-1:0]       evtValid,
  input  logic [NUM_EP*ERR_W-1:0] evtErr,
  input  logic [NUM_EP-1:0]       evtOk,
  input  logic [NUM_EP-1:0]       evtPid,
  output logic [7:0]              rdData,
  output logic                    rdValid,
  output logic                    ctrlBufEn,
  output logic                    validateStb,
  output logic                    clearStb,
  output logic [3:0]              bufEp,
  output logic                    cmdReject
);

  dpStrb_t strb;
  logic    ovwFlag, setupInBuf;

  ep_status_ctrl #(
    .NUM_EP(NUM_EP), .CTRL_EPS(CTRL_EPS), .RD_BASE(RD_BASE),
    .VAL_BASE(VAL_BASE), .CLR_BASE(CLR_BASE), .ACK_CODE(ACK_CODE),
    .IMG_CODE(IMG_CODE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .setupRcvd(setupRcvd), .setupWriteDone(setupWriteDone),
    .strb(strb), .validateStb(validateStb), .clearStb(clearStb),
    .bufEp(bufEp), .cmdReject(cmdReject), .ctrlBufEn(ctrlBufEn),
    .ovwFlag(ovwFlag), .setupInBuf(setupInBuf)
  );

  ep_status_dp #(.NUM_EP(NUM_EP), .ERR_W(ERR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .imgBits({ovwFlag, setupInBuf, cpuBufSel}),
    .evtValid(evtValid), .evtErr(evtErr), .evtOk(evtOk), .evtPid(evtPid),
    .rdData(rdData), .rdValid(rdValid)
  );

  logic [7:0] valRel, clrRel;
  logic       ctrlBufCmd;
  assign valRel     = cmdCode - VAL_BASE;
  assign clrRel     = cmdCode - CLR_BASE;
  assign ctrlBufCmd = cmdValid && ((cmdCode >= VAL_BASE && valRel < 8'(CTRL_EPS)) ||
                                   (cmdCode >= CLR_BASE && clrRel < 8'(CTRL_EPS)));

  // R7: locked control endpoints refuse buffer commands
  p_lock_reject_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBufEn && ctrlBufCmd |=> cmdReject && !validateStb && !clearStb);

  // R8: acknowledge without a colliding set-up unlocks
  p_ack_unlock_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdCode == ACK_CODE && !setupRcvd |=> ctrlBufEn);

  // R7: a refusal only ever follows a locked state
  p_reject_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdReject |-> $past(!ctrlBufEn));

endmodule

// File: tb/ep_status_tracker_bench.sv
module ep_status_tracker_bench;

  localparam int NEP = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cmdValid = 1'b0;
  logic [7:0]       cmdCode = 8'h00;
  logic             cpuBufSel = 1'b0;
  logic             setupRcvd = 1'b0;
  logic             setupWriteDone = 1'b0;
  logic [NEP-1:0]   evtValid = '0;
  logic [NEP*4-1:0] evtErr = '0;
  logic [NEP-1:0]   evtOk = '0;
  logic [NEP-1:0]   evtPid = '0;
  logic [7:0]       rdData;
  logic             rdValid, ctrlBufEn, validateStb, clearStb, cmdReject;
  logic [3:0]       bufEp;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ep_status_tracker u_ep_status_tracker (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cpuBufSel(cpuBufSel), .setupRcvd(setupRcvd), .setupWriteDone(setupWriteDone),
    .evtValid(evtValid), .evtErr(evtErr), .evtOk(evtOk), .evtPid(evtPid),
    .rdData(rdData), .rdValid(rdValid), .ctrlBufEn(ctrlBufEn),
    .validateStb(validateStb), .clearStb(clearStb), .bufEp(bufEp),
    .cmdReject(cmdReject)
  );

  typedef struct packed {
    logic [3:0] ep;
    logic [3:0] err;
    logic       ok;
    logic       pid;
    logic       twice;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'd0,  4'h0, 1'b1, 1'b0, 1'b0, 8'h01},
    '{4'd1,  4'h5, 1'b0, 1'b1, 1'b0, 8'h4A},
    '{4'd15, 4'hF, 1'b0, 1'b0, 1'b1, 8'h9E},
    '{4'd7,  4'h0, 1'b1, 1'b1, 1'b1, 8'hC1},
    '{4'd2,  4'h3, 1'b0, 1'b1, 1'b0, 8'h46},
    '{4'd14, 4'hA, 1'b1, 1'b0, 1'b0, 8'h15}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic setEvt(input int ep, input logic [3:0] err, input logic ok, input logic pid);
    evtValid[ep]       = 1'b1;
    evtErr[ep*4 +: 4]  = err;
    evtOk[ep]          = ok;
    evtPid[ep]         = pid;
  endtask

  task automatic pulseEvt(input int ep, input logic [3:0] err, input logic ok, input logic pid);
    @(negedge clk);
    setEvt(ep, err, ok, pid);
    @(negedge clk);
    evtValid = '0;
  endtask

  // one command cycle; result sampled at the following negedge
  task automatic doCmd(input logic [7:0] code);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdCode  = code;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] code, input string req, input logic [7:0] exp);
    doCmd(code);
    check({req, " rdValid"}, {7'd0, rdValid}, 8'h01);
    check(req, rdData, exp);
  endtask

  task automatic pulseSetup();
    @(negedge clk);
    setupRcvd = 1'b1;
    @(negedge clk);
    setupRcvd = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R6: reset state
    check("R6 ctrlBufEn", {7'd0, ctrlBufEn}, 8'h01);
    check("R6 rdValid", {7'd0, rdValid}, 8'h00);
    check("R6 strobes", {5'd0, validateStb, clearStb, cmdReject}, 8'h00);
    doRead(8'hA3, "R6 status ep3", 8'h00);
    doRead(8'hB4, "R6 image", 8'h00);
    @(negedge clk);
    check("R1 rdValid single cycle", {7'd0, rdValid}, 8'h00);

    // R2/R3/R4: vector walk
    for (int i = 0; i < 6; i++) begin
      pulseEvt(int'(VECS[i].ep), VECS[i].err, VECS[i].ok, VECS[i].pid);
      if (VECS[i].twice)
        pulseEvt(int'(VECS[i].ep), VECS[i].err, VECS[i].ok, VECS[i].pid);
      doRead(8'hA0 + {4'd0, VECS[i].ep}, "R2 R3 status", VECS[i].exp);
      doRead(8'hA0 + {4'd0, VECS[i].ep}, "R4 reread", VECS[i].exp & 8'h7F);
    end

    // R5: read and event on endpoint 4 in one cycle
    pulseEvt(4, 4'h1, 1'b1, 1'b0);
    @(negedge clk);
    setEvt(4, 4'h2, 1'b0, 1'b1);
    cmdValid = 1'b1;
    cmdCode  = 8'hA4;
    @(negedge clk);
    cmdValid = 1'b0;
    evtValid = '0;
    check("R5 collide returns old", rdData, 8'h03);
    doRead(8'hA4, "R5 event kept", 8'hC4);
    doRead(8'hA4, "R5 then cleared", 8'h44);

    // R7: set-up lock
    pulseSetup();
    check("R7 lock", {7'd0, ctrlBufEn}, 8'h00);
    doCmd(8'h60);
    check("R7 validate ep0 rejected", {6'd0, validateStb, cmdReject}, 8'h01);
    @(negedge clk);
    check("R7 reject one cycle", {7'd0, cmdReject}, 8'h00);
    doCmd(8'h71);
    check("R7 clear ep1 rejected", {6'd0, clearStb, cmdReject}, 8'h01);
    doCmd(8'h65);
    check("R7 validate ep5 passes", {6'd0, validateStb, cmdReject}, 8'h02);
    check("R7 bufEp", {4'd0, bufEp}, 8'h05);

    // R9/R10: overwrite flag
    pulseSetup();
    doRead(8'hB4, "R9 R10 overwrite set", 8'h0C);
    doRead(8'hB4, "R10 kept without write done", 8'h0C);
    setupWriteDone = 1'b1;
    cpuBufSel      = 1'b1;
    doRead(8'hB4, "R10 read with write done", 8'h0E);
    doRead(8'hB4, "R10 cleared", 8'h06);

    // R8: acknowledge, and set-up colliding with acknowledge
    doCmd(8'hF4);
    check("R8 unlock", {7'd0, ctrlBufEn}, 8'h01);
    @(negedge clk);
    setupRcvd = 1'b1;
    cmdValid  = 1'b1;
    cmdCode   = 8'hF4;
    @(negedge clk);
    setupRcvd = 1'b0;
    cmdValid  = 1'b0;
    check("R8 set-up beats ack", {7'd0, ctrlBufEn}, 8'h00);
    doCmd(8'hF4);
    doCmd(8'h61);
    check("R8 validate ep1 after ack", {6'd0, validateStb, cmdReject}, 8'h02);

    // R11: clear on control OUT empties set-up buffer flag
    doCmd(8'h70);
    check("R11 clear ep0 strobe", {6'd0, clearStb, cmdReject}, 8'h02);
    doRead(8'hB4, "R11 set-up flag cleared", 8'h02);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule